// File: doc/BRIEF.md
# Command Queue Front End with Idle Interrupt

This block sits between a CPU register port and the first stage of a small geometry pipeline. Software writes vertex words into a 32-deep word queue. Before each burst it can read how many slots are free. A triangle assembler drains the queue and hands out complete triangles, each three vertex words wide, on a valid/ready port.

Every stage reports its own busy bit:

- the host write latch;
- the queue, which is busy whenever it is non-empty;
- the assembler.

These three bits form a pipe-state word. An interrupt unit compares that word against a programmable mask. It raises a level interrupt once every selected stage is idle, so the CPU can move on to other work instead of polling.

In list mode, one or two leftover vertices keep the assembler busy, which blocks the all-stages interrupt. Strip mode reuses the last two vertices, so the assembler is idle after every vertex. A mode write, or the soft-reset bit, empties the queue and throws away any half-built triangle.

Top module: `cmdq_front`

## Requirements
- R1: The SPACE register (read address 5) returns 32 minus the number of words held in the queue. It reads 32 after reset and 0 when the queue is full.
- R2: A data write (address 0) that reaches a full queue is discarded. It sets the sticky overflow flag in STATUS bit 1 (address 4). Writing 1 to STATUS bit 1 clears the flag.
- R3: PIPE (address 6) returns the busy bits: bit 0 is the host write latch, bit 1 is a non-empty queue, and bit 2 is the assembler. All three are 0 when the pipeline holds no data.
- R4: In list mode (MODE address 2, bit 0 = 0), every third vertex completes a triangle. `tri_data[31:0]` carries the first vertex, `[63:32]` the second and `[95:64]` the third. The triangle is held steady while `tri_ready` is low.
- R5: In list mode, while one or two vertices of an unfinished triangle are held, PIPE bit 2 stays 1. After 3n+1 vertices with mask 3'b111, the interrupt stays low.
- R6: In strip mode (MODE bit 0 = 1), every vertex from the third onward emits the triangle {previous-previous, previous, new}. PIPE bit 2 returns to 0 once the last triangle is taken.
- R7: The interrupt rises one cycle after all PIPE bits selected by MASK (address 1, bits 2:0, reset value 3'b111) read 0, provided a selected bit was 1 since the interrupt was last raised. It stays high as a level.
- R8: Writing 1 to STATUS bit 0 clears the interrupt. It stays low until a selected stage has been busy again and then gone idle.
- R9: With MASK = 3'b011, the interrupt fires even while a partial list triangle holds PIPE bit 2 at 1.
- R10: A write to MODE, or a write of 1 to CTRL bit 0 (address 3), empties the queue. It also drops any partial triangle and any pending output triangle. The sticky overflow flag is unaffected.
- R11: After reset, the interrupt is low, STATUS reads 0 and PIPE reads 0. The interrupt stays low until some selected stage has been busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tri_valid | output | 1 | Triangle output valid |
| tri_ready | input | 1 | Triangle output accepted by the next stage |
| tri_data | output | 96 | Three vertex words; the oldest vertex is in the low word |
| irq | output | 1 | Level interrupt when the selected stages are idle |

## Verification
The bench sends 3n+1 vertices in list mode and checks that the interrupt stays low with PIPE bit 2 set. A design that dropped or ignored the leftover vertex would raise the interrupt there, and it would also miscount the triangles that come out later. It then narrows the mask to the queue and host bits, and the interrupt must fire despite the partial triangle.

Strip mode is checked word by word against triangles built from a sliding window. A design that reset its window after each triangle would emit one triangle instead of three.

A queue overfilled by one word must still report zero free slots. It must set the sticky flag, and it must later produce exactly eleven triangles from thirty-five kept vertices. An off-by-one full test changes all three results.

Clearing the interrupt and then waiting with the pipeline idle catches a unit that re-fires without being re-armed.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic {
        ASM_LIST  = 1'b0,
        ASM_STRIP = 1'b1
    } asm_mode_e;

    localparam int unsigned PS_HOST = 0;
    localparam int unsigned PS_FIFO = 1;
    localparam int unsigned PS_ASM  = 2;
    localparam int unsigned PS_W    = 3;

    localparam logic [2:0] RA_DATA   = 3'd0;
    localparam logic [2:0] RA_MASK   = 3'd1;
    localparam logic [2:0] RA_MODE   = 3'd2;
    localparam logic [2:0] RA_CTRL   = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;
    localparam logic [2:0] RA_SPACE  = 3'd5;
    localparam logic [2:0] RA_PIPE   = 3'd6;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full     = (s_q.cnt == CW'(DEPTH));
    assign empty    = (s_q.cnt == '0);
    assign push_ok  = push && !full && !flush;
    assign pop_ok   = pop && !empty && !flush;
    assign pop_data = mem_q[s_q.rp];
    assign count    = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
            if (pop_ok)  s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
            s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wp] <= push_data;
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    assert_drop_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (s_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/cmdq_tri_asm.sv
module cmdq_tri_asm
    import cmdq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  asm_mode_e     mode,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_take,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [3*DW-1:0] out_tri,
    output logic          busy
);
    typedef struct packed {
        logic [1:0]      cnt;
        logic [DW-1:0]   va;
        logic [DW-1:0]   vb;
        logic            ov;
        logic [3*DW-1:0] tri_w;
    } asm_st_t;

    asm_st_t s_d, s_q;

    assign in_take   = in_valid && !flush && (!s_q.ov || out_ready);
    assign out_valid = s_q.ov;
    assign out_tri   = s_q.tri_w;
    assign busy      = s_q.ov || (mode == ASM_LIST && s_q.cnt != 2'd0);

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.cnt = '0;
            s_d.ov  = 1'b0;
        end else begin
            if (s_q.ov && out_ready) s_d.ov = 1'b0;
            if (in_take) begin
                case (s_q.cnt)
                    2'd0: begin
                        s_d.va  = in_data;
                        s_d.cnt = 2'd1;
                    end
                    2'd1: begin
                        s_d.vb  = in_data;
                        s_d.cnt = 2'd2;
                    end
                    default: begin
                        s_d.tri_w = {in_data, s_q.vb, s_q.va};
                        s_d.ov    = 1'b1;
                        if (mode == ASM_LIST) begin
                            s_d.cnt = 2'd0;
                        end else begin
                            s_d.va = s_q.vb;
                            s_d.vb = in_data;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ov && !out_ready && !flush) |=> (s_q.ov && $stable(s_q.tri_w)));

    assert_flush_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!out_valid && !busy));
endmodule

// File: rtl/cmdq_idle_irq.sv
module cmdq_idle_irq #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pipe,
    input  logic [W-1:0] mask,
    input  logic         clr,
    output logic         irq
);
    typedef struct packed {
        logic armed;
        logic irq;
    } irq_st_t;

    irq_st_t s_d, s_q;
    logic sel_busy, fire;

    assign sel_busy = |(pipe & mask);
    assign fire     = s_q.armed && !sel_busy;
    assign irq      = s_q.irq;

    always_comb begin
        s_d = s_q;
        if (fire) begin
            s_d.armed = 1'b0;
            s_d.irq   = 1'b1;
        end else begin
            s_d.armed = s_q.armed || sel_busy;
            if (clr) s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_irq_rise_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> ($past(pipe & mask) == '0));

    assert_irq_fall_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.irq) |-> $past(clr));
endmodule

// File: rtl/cmdq_front.sv
module cmdq_front
    import cmdq_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [2:0]      rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            tri_valid,
    input  logic            tri_ready,
    output logic [3*DW-1:0] tri_data,
    output logic            irq
);
    typedef struct packed {
        logic            hv;
        logic [DW-1:0]   hd;
        logic [PS_W-1:0] mask;
        asm_mode_e       mode;
        logic            ovf;
    } top_st_t;

    top_st_t s_d, s_q;

    logic            flush, irq_clr;
    logic            f_full, f_empty, take;
    logic [DW-1:0]   f_data;
    logic [CW-1:0]   f_count;
    logic            asm_busy;
    logic [PS_W-1:0] pipe;

    assign flush   = wr_en && ((wr_addr == RA_MODE) || (wr_addr == RA_CTRL && wr_data[0]));
    assign irq_clr = wr_en && (wr_addr == RA_STATUS) && wr_data[0];

    cmdq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(s_q.hv), .push_data(s_q.hd),
        .pop(take), .pop_data(f_data),
        .count(f_count), .full(f_full), .empty(f_empty)
    );

    cmdq_tri_asm #(.DW(DW)) u_asm (
        .clk(clk), .rst_n(rst_n), .flush(flush), .mode(s_q.mode),
        .in_valid(!f_empty), .in_data(f_data), .in_take(take),
        .out_valid(tri_valid), .out_ready(tri_ready), .out_tri(tri_data),
        .busy(asm_busy)
    );

    always_comb begin
        pipe          = '0;
        pipe[PS_HOST] = s_q.hv;
        pipe[PS_FIFO] = !f_empty;
        pipe[PS_ASM]  = asm_busy;
    end

    cmdq_idle_irq #(.W(PS_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .pipe(pipe), .mask(s_q.mask),
        .clr(irq_clr), .irq(irq)
    );

    always_comb begin
        s_d    = s_q;
        s_d.hv = 1'b0;
        if (s_q.hv && f_full && !flush) s_d.ovf = 1'b1;
        else if (wr_en && wr_addr == RA_STATUS && wr_data[1]) s_d.ovf = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                RA_DATA: begin
                    s_d.hv = 1'b1;
                    s_d.hd = wr_data;
                end
                RA_MASK: s_d.mask = wr_data[PS_W-1:0];
                RA_MODE: s_d.mode = asm_mode_e'(wr_data[0]);
                default: ;
            endcase
        end
        if (flush) s_d.hv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
            s_q.mode <= ASM_LIST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_MASK:   rd_data[PS_W-1:0] = s_q.mask;
            RA_MODE:   rd_data[0]        = s_q.mode;
            RA_STATUS: rd_data[1:0]      = {s_q.ovf, irq};
            RA_SPACE:  rd_data[CW-1:0]   = CW'(DEPTH) - f_count;
            RA_PIPE:   rd_data[PS_W-1:0] = pipe;
            default:   ;
        endcase
    end

    assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.ovf) |-> $past(wr_en && wr_addr == RA_STATUS && wr_data[1]));

    assert_host_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hv && !(wr_en && wr_addr == RA_DATA)) |=> !s_q.hv);
endmodule

// File: tb/cmdq_front_test.sv
module cmdq_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tri_valid;
    logic        tri_ready = 1'b1;
    logic [95:0] tri_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [95:0] tri_log [64];
    int tri_n = 0;

    always #4 clk = ~clk;

    cmdq_front uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tri_valid(tri_valid), .tri_ready(tri_ready), .tri_data(tri_data),
        .irq(irq)
    );

    always @(negedge clk) begin
        #2;
        if (rst_n && tri_valid && tri_ready) begin
            if (tri_n < 64) tri_log[tri_n] = tri_data;
            tri_n++;
        end
    end

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [95:0] tri3(input logic [31:0] a, b, c);
        return {c, b, a};
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R11 / R1 / R3 reset state
        reg_rd(3'd5, v); check("R1 reset space", v, 32);
        reg_rd(3'd6, v); check("R11 reset pipe", v, 0);
        reg_rd(3'd4, v); check("R11 reset status", v, 0);
        reg_rd(3'd1, v); check("R7 reset mask", v, 7);
        idle(10);
        check("R11 irq idle without activity", irq, 0);

        // R4 list mode, six vertices
        tri_n = 0;
        for (int i = 0; i < 6; i++) reg_wr(3'd0, 32'h1000_0000 + i);
        idle(15);
        check("R4 list triangle count", tri_n, 2);
        for (int k = 0; k < 2; k++)
            check("R4 list triangle words", tri_log[k],
                  tri3(32'h1000_0000 + 3*k, 32'h1000_0001 + 3*k, 32'h1000_0002 + 3*k));
        reg_rd(3'd6, v); check("R3 pipe idle after list", v, 0);
        check("R7 irq after full idle", irq, 1);

        // R8 clear, stays low
        reg_wr(3'd4, 32'h1);
        idle(8);
        check("R8 irq cleared and not re-armed", irq, 0);

        // R5 3n+1 vertices
        tri_n = 0;
        for (int i = 0; i < 4; i++) reg_wr(3'd0, 32'h2000_0000 + i);
        idle(15);
        check("R5 one triangle from four", tri_n, 1);
        reg_rd(3'd6, v); check("R5 asm bit held by leftover", v, 4);
        check("R5 irq blocked by leftover", irq, 0);

        // R9 narrower mask
        reg_wr(3'd1, 32'h3);
        idle(3);
        check("R9 irq with fifo and host mask", irq, 1);
        reg_wr(3'd4, 32'h1);
        idle(2);

        // R10 mode change flushes partial
        reg_wr(3'd2, 32'h1);
        idle(2);
        reg_rd(3'd6, v); check("R10 mode write drops partial", v, 0);
        reg_wr(3'd1, 32'h7);
        idle(4);
        check("R8 no irq before new activity", irq, 0);

        // R6 strip mode, five vertices
        tri_n = 0;
        for (int i = 0; i < 5; i++) reg_wr(3'd0, 32'h5000_0000 + i);
        idle(15);
        check("R6 strip triangle count", tri_n, 3);
        for (int k = 0; k < 3; k++)
            check("R6 strip window", tri_log[k],
                  tri3(32'h5000_0000 + k, 32'h5000_0001 + k, 32'h5000_0002 + k));
        reg_rd(3'd6, v); check("R6 strip idle after last", v, 0);
        check("R7 irq after strip", irq, 1);
        reg_wr(3'd4, 32'h1);

        // R2 overflow in list mode with stalled output
        tri_ready = 1'b0;
        reg_wr(3'd2, 32'h0);
        reg_wr(3'd3, 32'h1);
        for (int i = 0; i < 35; i++) reg_wr(3'd0, 32'h7000_0000 + i);
        idle(5);
        reg_rd(3'd5, v); check("R1 space zero when full", v, 0);
        reg_rd(3'd4, v); check("R2 no overflow yet", v[1], 0);
        check("R4 triangle held while stalled", tri_data,
              tri3(32'h7000_0000, 32'h7000_0001, 32'h7000_0002));
        reg_wr(3'd0, 32'hDEAD_BEEF);
        idle(5);
        reg_rd(3'd4, v); check("R2 overflow flag set", v[1], 1);
        reg_rd(3'd5, v); check("R2 dropped word keeps full", v, 0);
        reg_wr(3'd4, 32'h2);
        reg_rd(3'd4, v); check("R2 overflow cleared", v[1], 0);
        tri_n = 0;
        tri_ready = 1'b1;
        idle(60);
        check("R2 eleven triangles from kept words", tri_n, 11);
        check("R4 first drained triangle", tri_log[0],
              tri3(32'h7000_0000, 32'h7000_0001, 32'h7000_0002));
        check("R4 last drained triangle", tri_log[10],
              tri3(32'h7000_001E, 32'h7000_001F, 32'h7000_0020));
        reg_rd(3'd6, v); check("R5 leftover after drain", v, 4);
        check("R5 irq blocked after drain", irq, 0);

        // R10 soft reset
        reg_wr(3'd3, 32'h1);
        idle(3);
        reg_rd(3'd6, v); check("R10 soft reset clears pipe", v, 0);
        reg_rd(3'd5, v); check("R10 soft reset space", v, 32);
        check("R10 irq after discard", irq, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule